// File: doc/BRIEF.md
# CAN message object flag manager

This block holds the control and status flags for a small array of CAN message objects, 16 by default. A message handler reports two kinds of event, each tagged with an object index: a received frame stored into an object, or a frame sent successfully from an object. For each event the block updates the object's flags: unread data, overwritten data, interrupt pending and data length. It then reports one prioritised interrupt identifier. Frame payloads, bit timing and bus signalling are handled elsewhere.

Software reaches the objects through an interface register set of three words: a control word, an arbitration word and a mask word. It loads the words and then starts a transfer that either copies them into an object or loads them from an object. The transfer takes a fixed number of cycles and holds a busy flag high for that time. A combinational acceptance check tests an incoming arbitration word against a chosen object. It compares the words exactly, or compares only the bits selected by the object's mask.

Top module: `can_mobj_flags`

## Requirements
- R1: After reset every object flag word, arbitration word and mask word is zero, the interface words read zero, `xfer_busy` is low and `int_id` is 0.
- R2: The control word layout is: bit 15 unread-data, bit 14 lost-message, bit 13 interrupt-pending, bit 12 use-mask, bit 11 transmit-interrupt-enable, bit 10 receive-interrupt-enable, bit 9 remote-enable, bit 8 transmit-request, bit 7 end-of-block and bits 3..0 the data length. Bits 31..16 and 6..4 always read as zero.
- R3: A start pulse seen while idle makes `xfer_busy` high for exactly XFER_CYC cycles. The object is updated at the clock edge where busy falls. While busy is high, start pulses and writes to the interface words are ignored.
- R4: A write transfer (`xfer_write`=1) copies the three interface words into the object. A read transfer copies the object's three words into the interface words.
- R5: A receive event (`hnd_evt_tx`=0) sets the object's unread-data bit and copies `hnd_evt_dlc` into bits 3..0. It sets interrupt-pending only when receive-interrupt-enable is 1.
- R6: A receive event sets lost-message when the object's unread-data bit is already 1 and the object is a receive object (arbitration bit 30 = 0). It never sets lost-message on a transmit object (bit 30 = 1).
- R7: A transmit-done event (`hnd_evt_tx`=1) sets interrupt-pending when transmit-interrupt-enable is 1. Otherwise it leaves the whole object word unchanged.
- R8: `int_id` is 1 plus the index of the lowest-numbered object whose interrupt-pending bit is set, or 0 when no object is pending. `int_line` is high exactly when `int_id` is nonzero.
- R9: When a write transfer commits to an object in the same cycle as a handler event to that object, the object takes the written control word. A lost-message bit newly set by the event is still kept.
- R10: With use-mask 0, `acc_hit` is 1 only when all 31 bits of `acc_arb` (identifier 28..0, extended flag 29, direction 30) equal the object's arbitration word.
- R11: With use-mask 1, only the bit positions where the object's mask word is 1 are compared. Mask bit 29 covers the extended flag and bit 30 covers the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifc_ctl_we | input | 1 | Load interface control word |
| ifc_ctl_wdata | input | 32 | Control word to load |
| ifc_arb_we | input | 1 | Load interface arbitration word |
| ifc_arb_wdata | input | 31 | Arbitration word: id 28..0, extended 29, direction 30 |
| ifc_msk_we | input | 1 | Load interface mask word |
| ifc_msk_wdata | input | 31 | Mask word, same bit layout as arbitration |
| xfer_start | input | 1 | Start a transfer |
| xfer_write | input | 1 | 1 = interface to object, 0 = object to interface |
| xfer_obj | input | IDX_W | Object index of the transfer |
| xfer_busy | output | 1 | Transfer in progress |
| ifc_ctl_rdata | output | 32 | Interface control word |
| ifc_arb_rdata | output | 31 | Interface arbitration word |
| ifc_msk_rdata | output | 31 | Interface mask word |
| hnd_evt_vld | input | 1 | Handler event strobe |
| hnd_evt_tx | input | 1 | 0 = receive store, 1 = transmit done |
| hnd_evt_obj | input | IDX_W | Object index of the event |
| hnd_evt_dlc | input | 4 | Data length of a received frame |
| acc_obj | input | IDX_W | Object tested by the acceptance check |
| acc_arb | input | 31 | Incoming arbitration word |
| acc_hit | output | 1 | Incoming word is accepted by the object |
| int_id | output | ID_W | Identifier of the pending object, 0 = none |
| int_line | output | 1 | Interrupt request |

## Verification
The bench drives a second receive into an object that has not been read, with and without a transmit direction. A design that ignores direction, or that tests the unread bit after it has already been updated, shows a wrong lost-message bit. A handler event is placed on exactly the commit edge of a write transfer to the same object: a design with the wrong precedence either drops the new lost-message bit or keeps the unread bit that was cleared. Writes and a second start are issued in the middle of a transfer to catch a missing write protection. Several objects are left pending at once and cleared in turn, which exposes a priority encoder that picks the highest index or is off by one.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int CTL_W    = 16;
  localparam int DLC_W    = 4;
  localparam int CANID_W  = 29;
  localparam int ARB_W    = CANID_W + 2;
  localparam int A_XTD    = CANID_W;
  localparam int A_DIR    = CANID_W + 1;

  localparam int F_NEWDAT = 15;
  localparam int F_MSGLST = 14;
  localparam int F_INTPND = 13;
  localparam int F_UMASK  = 12;
  localparam int F_TXIE   = 11;
  localparam int F_RXIE   = 10;
  localparam int F_RMTEN  = 9;
  localparam int F_TXRQST = 8;
  localparam int F_EOB    = 7;

  // bits that hold state; 6..4 are reserved and read as zero
  localparam logic [CTL_W-1:0] CTL_LIVE = 16'hFF8F;

  typedef logic [CTL_W-1:0] ctl_t;
  typedef logic [ARB_W-1:0] arb_t;
endpackage

// File: rtl/cmf_obj_store.sv
module cmf_obj_store
  import cmf_pkg::*;
#(
  parameter int NUM_OBJ = 16,
  parameter int IDX_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          evt_vld,
  input  logic                          evt_tx,
  input  logic [IDX_W-1:0]              evt_obj,
  input  logic [DLC_W-1:0]              evt_dlc,
  input  logic                          cmt_wr,
  input  logic [IDX_W-1:0]              cmt_obj,
  input  logic [CTL_W-1:0]              cmt_ctl,
  input  logic [ARB_W-1:0]              cmt_arb,
  input  logic [ARB_W-1:0]              cmt_msk,
  output logic [NUM_OBJ-1:0][CTL_W-1:0] ctl_q,
  output logic [NUM_OBJ-1:0][ARB_W-1:0] arb_q,
  output logic [NUM_OBJ-1:0][ARB_W-1:0] msk_q
);

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic hit;
    logic cw;
    logic en;
    ctl_t h_ctl;
    ctl_t ctl_d;
    arb_t arb_d;
    arb_t msk_d;

    always_comb begin
      hit   = evt_vld && (evt_obj == IDX_W'(g));
      cw    = cmt_wr && (cmt_obj == IDX_W'(g));
      h_ctl = ctl_q[g];
      if (hit && !evt_tx) begin
        h_ctl[F_NEWDAT] = 1'b1;
        if (!arb_q[g][A_DIR] && ctl_q[g][F_NEWDAT]) begin
          h_ctl[F_MSGLST] = 1'b1;
        end
        if (ctl_q[g][F_RXIE]) begin
          h_ctl[F_INTPND] = 1'b1;
        end
        h_ctl[DLC_W-1:0] = evt_dlc;
      end
      if (hit && evt_tx && ctl_q[g][F_TXIE]) begin
        h_ctl[F_INTPND] = 1'b1;
      end
      ctl_d = h_ctl;
      if (cw) begin
        ctl_d           = cmt_ctl & CTL_LIVE;
        ctl_d[F_MSGLST] = cmt_ctl[F_MSGLST] | (h_ctl[F_MSGLST] & ~ctl_q[g][F_MSGLST]);
      end
      arb_d = cw ? cmt_arb : arb_q[g];
      msk_d = cw ? cmt_msk : msk_q[g];
      en    = hit | cw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[g] <= '0;
        arb_q[g] <= '0;
        msk_q[g] <= '0;
      end else if (en) begin
        ctl_q[g] <= ctl_d;
        arb_q[g] <= arb_d;
        msk_q[g] <= msk_d;
      end
    end

    // R6
    msglst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[g][F_MSGLST]) |->
        ($past(hit && !evt_tx && ctl_q[g][F_NEWDAT] && !arb_q[g][A_DIR]) || $past(cw)));

    // R5
    newdat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !evt_tx && !cw) |=> ctl_q[g][F_NEWDAT]);

    // R7
    txie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && evt_tx && !ctl_q[g][F_TXIE] && !cw) |=> $stable(ctl_q[g]));
  end

endmodule

// File: rtl/cmf_xfer_ctrl.sv
module cmf_xfer_ctrl
  import cmf_pkg::*;
#(
  parameter int XFER_CYC = 3,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             arb_we,
  input  logic [ARB_W-1:0] arb_wdata,
  input  logic             msk_we,
  input  logic [ARB_W-1:0] msk_wdata,
  input  logic             start,
  input  logic             start_wr,
  input  logic [IDX_W-1:0] start_obj,
  input  logic [CTL_W-1:0] obj_ctl,
  input  logic [ARB_W-1:0] obj_arb,
  input  logic [ARB_W-1:0] obj_msk,
  output logic             busy,
  output logic             cmt_wr,
  output logic [IDX_W-1:0] cur_obj,
  output logic [CTL_W-1:0] ifc_ctl,
  output logic [ARB_W-1:0] ifc_arb,
  output logic [ARB_W-1:0] ifc_msk
);

  localparam int CNT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_CYC - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wr_q;
  logic [IDX_W-1:0] obj_q;
  logic             launch;
  logic             cmt;
  logic             rd_load;
  ctl_t             ctl_q, ctl_d;
  arb_t             arb_q, arb_d;
  arb_t             msk_q, msk_d;
  logic             ifc_en;

  always_comb begin
    cmt     = busy_q && (cnt_q == CNT_LAST);
    launch  = !busy_q && start;
    rd_load = cmt && !wr_q;
    busy_d  = busy_q;
    if (cmt) begin
      busy_d = 1'b0;
    end else if (launch) begin
      busy_d = 1'b1;
    end
    cnt_en = busy_q || launch;
    cnt_d  = (busy_q && !cmt) ? cnt_q + CNT_W'(1) : '0;
  end

  always_comb begin
    ctl_d  = ctl_q;
    arb_d  = arb_q;
    msk_d  = msk_q;
    ifc_en = 1'b0;
    if (rd_load) begin
      ctl_d  = obj_ctl & CTL_LIVE;
      arb_d  = obj_arb;
      msk_d  = obj_msk;
      ifc_en = 1'b1;
    end else if (!busy_q) begin
      if (ctl_we) ctl_d = ctl_wdata & CTL_LIVE;
      if (arb_we) arb_d = arb_wdata;
      if (msk_we) msk_d = msk_wdata;
      ifc_en = ctl_we | arb_we | msk_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      obj_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (launch) begin
        wr_q  <= start_wr;
        obj_q <= start_obj;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      arb_q <= '0;
      msk_q <= '0;
    end else if (ifc_en) begin
      ctl_q <= ctl_d;
      arb_q <= arb_d;
      msk_q <= msk_d;
    end
  end

  assign busy    = busy_q;
  assign cmt_wr  = cmt && wr_q;
  assign cur_obj = obj_q;
  assign ifc_ctl = ctl_q;
  assign ifc_arb = arb_q;
  assign ifc_msk = msk_q;

  // R3
  ifc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_load) |=> ($stable(ctl_q) && $stable(arb_q) && $stable(msk_q)));

  // R3
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != CNT_LAST)) |=> (busy_q && $stable(obj_q) && $stable(wr_q)));

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q == CNT_LAST)) |=> !busy_q);

endmodule

// File: rtl/cmf_irq_arb.sv
module cmf_irq_arb #(
  parameter int NUM_OBJ = 16,
  parameter int ID_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] pend,
  output logic [ID_W-1:0]    int_id
);

  always_comb begin
    int_id = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend[i]) int_id = ID_W'(i + 1);
    end
  end

  // R8
  id_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id != '0) |-> (|(pend & (NUM_OBJ'(1) << (int_id - ID_W'(1))))));

  // R8
  id_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id != '0) |-> ((pend & ((NUM_OBJ'(1) << (int_id - ID_W'(1))) - NUM_OBJ'(1))) == '0));

  // R8
  id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (int_id == '0));

endmodule

// File: rtl/cmf_accept.sv
module cmf_accept
  import cmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_msk,
  input  logic [ARB_W-1:0] obj_arb,
  input  logic [ARB_W-1:0] obj_msk,
  input  logic [ARB_W-1:0] rx_arb,
  output logic             hit
);

  arb_t care;

  always_comb begin
    care = use_msk ? obj_msk : '1;
    hit  = ((rx_arb ^ obj_arb) & care) == '0;
  end

  // R10
  exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_msk && hit) |-> (rx_arb == obj_arb));

  // R11
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_msk && ((rx_arb & obj_msk) == (obj_arb & obj_msk))) |-> hit);

endmodule

// File: rtl/can_mobj_flags.sv
module can_mobj_flags
  import cmf_pkg::*;
#(
  parameter int NUM_OBJ  = 16,
  parameter int XFER_CYC = 3,
  localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
  localparam int ID_W    = $clog2(NUM_OBJ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ifc_ctl_we,
  input  logic [31:0]      ifc_ctl_wdata,
  input  logic             ifc_arb_we,
  input  logic [ARB_W-1:0] ifc_arb_wdata,
  input  logic             ifc_msk_we,
  input  logic [ARB_W-1:0] ifc_msk_wdata,
  input  logic             xfer_start,
  input  logic             xfer_write,
  input  logic [IDX_W-1:0] xfer_obj,
  output logic             xfer_busy,
  output logic [31:0]      ifc_ctl_rdata,
  output logic [ARB_W-1:0] ifc_arb_rdata,
  output logic [ARB_W-1:0] ifc_msk_rdata,
  input  logic             hnd_evt_vld,
  input  logic             hnd_evt_tx,
  input  logic [IDX_W-1:0] hnd_evt_obj,
  input  logic [DLC_W-1:0] hnd_evt_dlc,
  input  logic [IDX_W-1:0] acc_obj,
  input  logic [ARB_W-1:0] acc_arb,
  output logic             acc_hit,
  output logic [ID_W-1:0]  int_id,
  output logic             int_line
);

  logic [1:0]                    rst_sync_q;
  logic                          core_rst_n;
  logic [NUM_OBJ-1:0][CTL_W-1:0] ctl_q;
  logic [NUM_OBJ-1:0][ARB_W-1:0] arb_q;
  logic [NUM_OBJ-1:0][ARB_W-1:0] msk_q;
  logic [NUM_OBJ-1:0]            pend;
  logic                          cmt_wr;
  logic [IDX_W-1:0]              cur_obj;
  ctl_t                          ifc_ctl;
  arb_t                          ifc_arb;
  arb_t                          ifc_msk;
  logic [15:0]                   unused_ctl_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n    = rst_sync_q[1];
  assign unused_ctl_hi = ifc_ctl_wdata[31:16];

  cmf_xfer_ctrl #(
    .XFER_CYC (XFER_CYC),
    .IDX_W    (IDX_W)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ctl_we    (ifc_ctl_we),
    .ctl_wdata (ifc_ctl_wdata[CTL_W-1:0]),
    .arb_we    (ifc_arb_we),
    .arb_wdata (ifc_arb_wdata),
    .msk_we    (ifc_msk_we),
    .msk_wdata (ifc_msk_wdata),
    .start     (xfer_start),
    .start_wr  (xfer_write),
    .start_obj (xfer_obj),
    .obj_ctl   (ctl_q[cur_obj]),
    .obj_arb   (arb_q[cur_obj]),
    .obj_msk   (msk_q[cur_obj]),
    .busy      (xfer_busy),
    .cmt_wr    (cmt_wr),
    .cur_obj   (cur_obj),
    .ifc_ctl   (ifc_ctl),
    .ifc_arb   (ifc_arb),
    .ifc_msk   (ifc_msk)
  );

  cmf_obj_store #(
    .NUM_OBJ (NUM_OBJ),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .evt_vld (hnd_evt_vld),
    .evt_tx  (hnd_evt_tx),
    .evt_obj (hnd_evt_obj),
    .evt_dlc (hnd_evt_dlc),
    .cmt_wr  (cmt_wr),
    .cmt_obj (cur_obj),
    .cmt_ctl (ifc_ctl),
    .cmt_arb (ifc_arb),
    .cmt_msk (ifc_msk),
    .ctl_q   (ctl_q),
    .arb_q   (arb_q),
    .msk_q   (msk_q)
  );

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_pend
    assign pend[g] = ctl_q[g][F_INTPND];
  end

  cmf_irq_arb #(
    .NUM_OBJ (NUM_OBJ),
    .ID_W    (ID_W)
  ) u_irq (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .pend   (pend),
    .int_id (int_id)
  );

  cmf_accept u_acc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .use_msk (ctl_q[acc_obj][F_UMASK]),
    .obj_arb (arb_q[acc_obj]),
    .obj_msk (msk_q[acc_obj]),
    .rx_arb  (acc_arb),
    .hit     (acc_hit)
  );

  assign int_line      = (int_id != '0);
  assign ifc_ctl_rdata = {16'h0000, ifc_ctl};
  assign ifc_arb_rdata = ifc_arb;
  assign ifc_msk_rdata = ifc_msk;

endmodule

// File: tb/sim_can_mobj_flags.sv
`timescale 1ns/1ps
module sim_can_mobj_flags;
  localparam int NUM  = 16;
  localparam int XFER = 3;
  localparam int IW   = 4;
  localparam int IDW  = 5;
  localparam logic [30:0] DIRB = 31'h4000_0000;
  localparam logic [30:0] XTDB = 31'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ifc_ctl_we = 0, ifc_arb_we = 0, ifc_msk_we = 0;
  logic [31:0] ifc_ctl_wdata = '0;
  logic [30:0] ifc_arb_wdata = '0, ifc_msk_wdata = '0;
  logic xfer_start = 0, xfer_write = 0;
  logic [IW-1:0] xfer_obj = '0;
  logic xfer_busy;
  logic [31:0] ifc_ctl_rdata;
  logic [30:0] ifc_arb_rdata, ifc_msk_rdata;
  logic hnd_evt_vld = 0, hnd_evt_tx = 0;
  logic [IW-1:0] hnd_evt_obj = '0;
  logic [3:0] hnd_evt_dlc = '0;
  logic [IW-1:0] acc_obj = '0;
  logic [30:0] acc_arb = '0;
  logic acc_hit;
  logic [IDW-1:0] int_id;
  logic int_line;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_mobj_flags #(.NUM_OBJ(NUM), .XFER_CYC(XFER)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ifc_ctl_we(ifc_ctl_we), .ifc_ctl_wdata(ifc_ctl_wdata),
    .ifc_arb_we(ifc_arb_we), .ifc_arb_wdata(ifc_arb_wdata),
    .ifc_msk_we(ifc_msk_we), .ifc_msk_wdata(ifc_msk_wdata),
    .xfer_start(xfer_start), .xfer_write(xfer_write), .xfer_obj(xfer_obj),
    .xfer_busy(xfer_busy), .ifc_ctl_rdata(ifc_ctl_rdata),
    .ifc_arb_rdata(ifc_arb_rdata), .ifc_msk_rdata(ifc_msk_rdata),
    .hnd_evt_vld(hnd_evt_vld), .hnd_evt_tx(hnd_evt_tx),
    .hnd_evt_obj(hnd_evt_obj), .hnd_evt_dlc(hnd_evt_dlc),
    .acc_obj(acc_obj), .acc_arb(acc_arb), .acc_hit(acc_hit),
    .int_id(int_id), .int_line(int_line)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ctl [NUM];
  logic [30:0] m_arb [NUM];
  logic [30:0] m_msk [NUM];
  logic [15:0] n_ctl [NUM];
  logic [15:0] m_if_ctl;
  logic [30:0] m_if_arb, m_if_msk;
  bit m_busy, m_wr;
  int m_cnt, m_obj;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) begin
        m_ctl[i] = '0; m_arb[i] = '0; m_msk[i] = '0;
      end
      m_if_ctl = '0; m_if_arb = '0; m_if_msk = '0;
      m_busy = 0; m_wr = 0; m_cnt = 0; m_obj = 0;
    end else begin
      bit commit;
      for (int i = 0; i < NUM; i++) n_ctl[i] = m_ctl[i];
      if (hnd_evt_vld) begin
        int o;
        o = int'(hnd_evt_obj);
        if (!hnd_evt_tx) begin
          n_ctl[o][15] = 1'b1;
          if (m_ctl[o][15] && !m_arb[o][30]) n_ctl[o][14] = 1'b1;
          if (m_ctl[o][10]) n_ctl[o][13] = 1'b1;
          n_ctl[o][3:0] = hnd_evt_dlc;
        end else if (m_ctl[o][11]) begin
          n_ctl[o][13] = 1'b1;
        end
      end
      commit = m_busy && (m_cnt == XFER - 1);
      if (commit && m_wr) begin
        bit fresh_lost;
        fresh_lost = n_ctl[m_obj][14] && !m_ctl[m_obj][14];
        n_ctl[m_obj] = m_if_ctl;
        if (fresh_lost) n_ctl[m_obj][14] = 1'b1;
        m_arb[m_obj] = m_if_arb;
        m_msk[m_obj] = m_if_msk;
      end
      if (commit && !m_wr) begin
        m_if_ctl = m_ctl[m_obj]; m_if_arb = m_arb[m_obj]; m_if_msk = m_msk[m_obj];
      end else if (!m_busy) begin
        if (ifc_ctl_we) m_if_ctl = ifc_ctl_wdata[15:0] & 16'hFF8F;
        if (ifc_arb_we) m_if_arb = ifc_arb_wdata;
        if (ifc_msk_we) m_if_msk = ifc_msk_wdata;
      end
      if (commit) m_busy = 0;
      else if (m_busy) m_cnt++;
      else if (xfer_start) begin
        m_busy = 1; m_cnt = 0; m_obj = int'(xfer_obj); m_wr = xfer_write;
      end
      for (int i = 0; i < NUM; i++) m_ctl[i] = n_ctl[i];
    end
  end

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      int eid;
      logic [30:0] care;
      bit ehit;
      eid = 0;
      for (int i = NUM - 1; i >= 0; i--) if (m_ctl[i][13]) eid = i + 1;
      care = m_ctl[acc_obj][12] ? m_msk[acc_obj] : '1;
      ehit = ((acc_arb ^ m_arb[acc_obj]) & care) == '0;
      chk(xfer_busy === m_busy, "R3 busy", 32'(xfer_busy), 32'(m_busy));
      chk(int_id === IDW'(eid), "R8 int_id", 32'(int_id), 32'(eid));
      chk(int_line === (eid != 0), "R8 int_line", 32'(int_line), 32'(eid != 0));
      chk(ifc_ctl_rdata === {16'h0, m_if_ctl}, "R4 ifc ctl", ifc_ctl_rdata, {16'h0, m_if_ctl});
      chk(ifc_arb_rdata === m_if_arb, "R4 ifc arb", 32'(ifc_arb_rdata), 32'(m_if_arb));
      chk(ifc_msk_rdata === m_if_msk, "R4 ifc msk", 32'(ifc_msk_rdata), 32'(m_if_msk));
      chk(acc_hit === ehit, m_ctl[acc_obj][12] ? "R11 acc_hit" : "R10 acc_hit",
          32'(acc_hit), 32'(ehit));
    end
  end

  task automatic set_ifc(input logic [31:0] c, input logic [30:0] a, input logic [30:0] m);
    @(negedge clk); #1;
    ifc_ctl_we = 1; ifc_arb_we = 1; ifc_msk_we = 1;
    ifc_ctl_wdata = c; ifc_arb_wdata = a; ifc_msk_wdata = m;
    @(negedge clk); #1;
    ifc_ctl_we = 0; ifc_arb_we = 0; ifc_msk_we = 0;
  endtask

  task automatic xfer(input bit wr, input int o);
    @(negedge clk); #1;
    xfer_start = 1; xfer_write = wr; xfer_obj = IW'(o);
    @(negedge clk); #1;
    xfer_start = 0;
    repeat (XFER) @(negedge clk);
  endtask

  task automatic evt(input bit tx, input int o, input logic [3:0] dlc);
    @(negedge clk); #1;
    hnd_evt_vld = 1; hnd_evt_tx = tx; hnd_evt_obj = IW'(o); hnd_evt_dlc = dlc;
    @(negedge clk); #1;
    hnd_evt_vld = 0;
  endtask

  task automatic expect_obj(input int o, input logic [15:0] exp, input string tag);
    xfer(0, o);
    chk(ifc_ctl_rdata === {16'h0, exp}, tag, ifc_ctl_rdata, {16'h0, exp});
  endtask

  task automatic acc_try(input int o, input logic [30:0] a, input bit exp, input string tag);
    @(negedge clk); #1;
    acc_obj = IW'(o); acc_arb = a;
    #1;
    chk(acc_hit === exp, tag, 32'(acc_hit), 32'(exp));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R3 watchdog: actual %h expected %h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(xfer_busy === 1'b0, "R1 busy", 32'(xfer_busy), 0);
    chk(int_id === '0, "R1 int_id", 32'(int_id), 0);
    chk(int_line === 1'b0, "R1 int_line", 32'(int_line), 0);
    chk(ifc_ctl_rdata === '0, "R1 ifc ctl", ifc_ctl_rdata, 0);
    cmp_en = 1;
    expect_obj(4, 16'h0000, "R1 object word");

    // R2 reserved bits read zero
    set_ifc(32'hFFFF_FFFF, '0, '0);
    chk(ifc_ctl_rdata === 32'h0000_FF8F, "R2 layout", ifc_ctl_rdata, 32'h0000_FF8F);

    // R3/R4 write with pokes during busy
    set_ifc(32'h0400, 31'h123, '0);
    @(negedge clk); #1;
    xfer_start = 1; xfer_write = 1; xfer_obj = 4'd3;
    @(negedge clk); #1;
    xfer_start = 1; xfer_write = 1; xfer_obj = 4'd9;
    ifc_ctl_we = 1; ifc_ctl_wdata = 32'hFFFF;
    @(negedge clk); #1;
    xfer_start = 0; ifc_ctl_we = 0;
    repeat (XFER - 1) @(negedge clk);
    chk(xfer_busy === 1'b0, "R3 busy dropped", 32'(xfer_busy), 0);
    expect_obj(3, 16'h0400, "R3 write kept");
    chk(ifc_arb_rdata === 31'h123, "R4 arb readback", 32'(ifc_arb_rdata), 32'h123);
    expect_obj(9, 16'h0000, "R3 start ignored");

    // R5 receive store
    evt(0, 3, 4'd5);
    expect_obj(3, 16'hA405, "R5 rx store");
    chk(int_id === 5'd4, "R8 id obj3", 32'(int_id), 4);
    // R6 overwrite
    evt(0, 3, 4'd7);
    expect_obj(3, 16'hE407, "R6 lost set");

    // R7 transmit with enable, R6 on transmit object
    set_ifc(32'h8800, DIRB | 31'h55, '0);
    xfer(1, 5);
    evt(1, 5, 4'd0);
    expect_obj(5, 16'hA800, "R7 tx sets pending");
    chk(int_id === 5'd4, "R8 lowest wins", 32'(int_id), 4);
    evt(0, 5, 4'd2);
    expect_obj(5, 16'hA802, "R6 no lost on tx object");

    // R7 transmit without enable
    set_ifc(32'h0100, DIRB, '0);
    xfer(1, 6);
    evt(1, 6, 4'd0);
    expect_obj(6, 16'h0100, "R7 tx ignored");

    // R8 clearing in turn
    set_ifc(32'h0400, 31'h123, '0);
    xfer(1, 3);
    chk(int_id === 5'd6, "R8 next pending", 32'(int_id), 6);
    set_ifc(32'h0800, DIRB | 31'h55, '0);
    xfer(1, 5);
    chk(int_id === 5'd0, "R8 none pending", 32'(int_id), 0);
    chk(int_line === 1'b0, "R8 line low", 32'(int_line), 0);

    // R9 collision on the commit edge
    set_ifc(32'h8000, '0, '0);
    xfer(1, 2);
    set_ifc(32'h0000, '0, '0);
    @(negedge clk); #1;
    xfer_start = 1; xfer_write = 1; xfer_obj = 4'd2;
    @(negedge clk); #1;
    xfer_start = 0;
    repeat (XFER - 1) @(negedge clk);
    #1;
    hnd_evt_vld = 1; hnd_evt_tx = 0; hnd_evt_obj = 4'd2; hnd_evt_dlc = 4'd9;
    @(negedge clk); #1;
    hnd_evt_vld = 0;
    expect_obj(2, 16'h4000, "R9 collision");

    // R10 exact compare
    acc_try(3, 31'h123, 1'b1, "R10 exact hit");
    acc_try(3, 31'h122, 1'b0, "R10 id differs");
    acc_try(3, DIRB | 31'h123, 1'b0, "R10 dir differs");

    // R11 masked compare
    set_ifc(32'h1000, XTDB | 31'h1F0, XTDB | 31'h0F0);
    xfer(1, 7);
    acc_try(7, DIRB | XTDB | 31'h0F5, 1'b1, "R11 masked hit");
    acc_try(7, XTDB | 31'h0E0, 1'b0, "R11 masked miss");
    acc_try(7, 31'h0F5, 1'b0, "R11 xtd masked in");

    repeat (3) @(negedge clk);
    cmp_en = 0;
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule